// File: doc/BRIEF.md
# Coefficient-Token Context Selector

This block supplies the context for coding the coefficient-count token of a 4x4 luma residual block. For the block being coded it looks up how many non-zero coefficients its left and upper neighbours had, forms the context value nC from those two counts, and maps nC onto one of four token code tables. A request flagged as a 2x2 chroma DC block bypasses the neighbour lookup and always yields nC = -1 with its own table code.

Neighbour counts are held in three position-indexed stores. A 16-entry file holds the counts of the macroblock being coded. A 4-entry file holds the right-column counts of the previously coded macroblock. A row memory holds the bottom-row counts of every macroblock in the row above. After each block is coded, the encoder writes the block's count back through a write port. The write lands in the current-macroblock file and, depending on the block's position, in the other two stores as well. Because blocks are coded in order, each entry is overwritten only after its last reader has used it. The row memory is enabled only on cycles that read or write it.

Top module: `ctxSel`

## Requirements
- R1: `ncValid` is high in the cycle after every cycle with `reqValid` high, and low in the cycle after every cycle with `reqValid` low; `ncOut` and `tableSel` are registered at that same edge.
- R2: When both neighbour counts nA and nB are available, nC = (nA + nB + 1) >> 1.
- R3: With only the left neighbour available nC = nA, with only the upper available nC = nB, and with neither nC = 0.
- R4: A request with `isChromaDc` high gives `ncOut` = -1 and `tableSel` = 4, whatever the stored counts and availability flags are, and it never enables the row memory.
- R5: For luma requests `tableSel` is 0 for nC 0..1, 1 for nC 2..3, 2 for nC 4..7, and 3 for nC of 8 or more.
- R6: Block index b has column x = {b[2], b[0]} and row y = {b[3], b[1]}. A left neighbour with x > 0 or an upper neighbour with y > 0 is read from the current-macroblock file and counts as available whatever `leftAvail` and `upAvail` are.
- R7: For a block with x = 0, nA is the count written for block (x = 3, same y) of the previous macroblock. It is available only when `leftAvail` is high.
- R8: For a block with y = 0, nB is the count written for block (same x, y = 3) while `mbCol` had the same value in the previous macroblock row. It is available only when `upAvail` is high.
- R9: `rowMemActive` is high exactly in cycles with a luma request for a block with y = 0 and `upAvail` high, or with a write for a block with y = 3.
- R10: After reset `ncValid`, `ncOut` and `tableSel` are 0, and every stored count reads as 0.
- R11: `wrEn` stores `wrCount` for block `wrBlk`. A request in the same cycle sees the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Context request for `blkIdx` |
| isChromaDc | input | 1 | Request is a 2x2 chroma DC block |
| blkIdx | input | 4 | Block index of the request, quadrant order |
| mbCol | input | $clog2(MB_PER_ROW) | Macroblock column within the row (requests and writes) |
| leftAvail | input | 1 | Left macroblock is available |
| upAvail | input | 1 | Upper macroblock is available |
| wrEn | input | 1 | Write the count of a finished block |
| wrBlk | input | 4 | Block index of the write |
| wrCount | input | CNT_W | Non-zero coefficient count to store |
| ncValid | output | 1 | `ncOut` and `tableSel` hold a fresh result |
| ncOut | output | CNT_W+1 | Context value nC, signed |
| tableSel | output | 3 | Token table: 0..3 luma, 4 chroma DC |
| rowMemActive | output | 1 | Row memory enable for this cycle |

## Verification
An exhaustive sweep of both internal neighbour counts over 0..16 covers every rounding case and every table boundary. Single-neighbour sweeps on edge blocks with the macroblock flags low show that only the available side counts. Whole frames of macroblocks are then coded with distinct count patterns under two availability schemes: normal edges, and a checkerboard of missing neighbours. Each of these frame passes tells apart the current-file, previous-macroblock and row-memory paths, and confirms that each entry is replaced only after its last reader. Chroma DC requests, a write that collides with a read, and the enable seen on each cycle separate the bypass, the read-before-write order and the gating of the row memory.

// File: rtl/ctxSelPkg.sv
package ctxSelPkg;

  localparam logic [2:0] TAB_CHROMA_DC = 3'd4;

  typedef struct packed {
    logic reqLive;
    logic chromaDc;
    logic leftInt;
    logic upInt;
    logic leftOk;
    logic upOk;
    logic rowRead;
    logic wrCur;
    logic wrRight;
    logic wrRow;
    logic rowCe;
  } ctxStrobe_t;

  typedef struct packed {
    logic [3:0] leftIdx;
    logic [3:0] upIdx;
    logic [1:0] rdX;
    logic [1:0] rdY;
    logic [1:0] wrX;
    logic [1:0] wrY;
  } ctxAddr_t;

  function automatic logic [1:0] blkX(input logic [3:0] b);
    return {b[2], b[0]};
  endfunction

  function automatic logic [1:0] blkY(input logic [3:0] b);
    return {b[3], b[1]};
  endfunction

  function automatic logic [3:0] blkAt(input logic [1:0] x, input logic [1:0] y);
    return {y[1], x[1], y[0], x[0]};
  endfunction

endpackage

// File: rtl/ctxSelCtrl.sv
module ctxSelCtrl
  import ctxSelPkg::*;
(
  input  logic       reqValid,
  input  logic       isChromaDc,
  input  logic [3:0] blkIdx,
  input  logic       leftAvail,
  input  logic       upAvail,
  input  logic       wrEn,
  input  logic [3:0] wrBlk,
  output ctxStrobe_t strobe,
  output ctxAddr_t   addr
);

  logic [1:0] curX, curY, wrX, wrY;
  logic       lumaReq;

  always_comb begin
    curX    = blkX(blkIdx);
    curY    = blkY(blkIdx);
    wrX     = blkX(wrBlk);
    wrY     = blkY(wrBlk);
    lumaReq = reqValid && !isChromaDc;

    strobe.reqLive  = reqValid;
    strobe.chromaDc = reqValid && isChromaDc;
    strobe.leftInt  = (curX != 2'd0);
    strobe.upInt    = (curY != 2'd0);
    strobe.leftOk   = lumaReq && ((curX != 2'd0) || leftAvail);
    strobe.upOk     = lumaReq && ((curY != 2'd0) || upAvail);
    strobe.rowRead  = lumaReq && (curY == 2'd0) && upAvail;
    strobe.wrCur    = wrEn;
    strobe.wrRight  = wrEn && (wrX == 2'd3);
    strobe.wrRow    = wrEn && (wrY == 2'd3);
    strobe.rowCe    = strobe.rowRead || strobe.wrRow;

    addr.leftIdx = blkAt(curX - 2'd1, curY);
    addr.upIdx   = blkAt(curX, curY - 2'd1);
    addr.rdX     = curX;
    addr.rdY     = curY;
    addr.wrX     = wrX;
    addr.wrY     = wrY;
  end

endmodule

// File: rtl/ctxSelDp.sv
module ctxSelDp
  import ctxSelPkg::*;
#(
  parameter int MB_PER_ROW = 22,
  parameter int CNT_W      = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctxStrobe_t                    strobe,
  input  ctxAddr_t                      addr,
  input  logic [$clog2(MB_PER_ROW)-1:0] mbCol,
  input  logic [3:0]                    wrBlk,
  input  logic [CNT_W-1:0]              wrCount,
  output logic                          ncValid,
  output logic signed [CNT_W:0]         ncOut,
  output logic [2:0]                    tableSel
);

  localparam int COL_W     = $clog2(MB_PER_ROW);
  localparam int ROW_DEPTH = MB_PER_ROW * 4;
  localparam int BLK_CNT   = 16;
  localparam int EDGE_CNT  = 4;

  logic [CNT_W-1:0] curFile   [BLK_CNT];
  logic [CNT_W-1:0] rightFile [EDGE_CNT];
  logic [CNT_W-1:0] rowMem    [ROW_DEPTH];

  logic [COL_W+1:0] rdRowAddr, wrRowAddr;
  logic [CNT_W-1:0] nA, nB, rowRdData, pick;
  logic [CNT_W:0]   sumAB;
  logic signed [CNT_W:0] ncNext;
  logic [2:0]       tableNext;

  assign rdRowAddr = {mbCol, addr.rdX};
  assign wrRowAddr = {mbCol, addr.wrX};

  // store writes; same-cycle reads see the previous contents
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BLK_CNT; i++) curFile[i] <= '0;
      for (int i = 0; i < EDGE_CNT; i++) rightFile[i] <= '0;
    end else begin
      if (strobe.wrCur)   curFile[wrBlk]       <= wrCount;
      if (strobe.wrRight) rightFile[addr.wrY]  <= wrCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ROW_DEPTH; i++) rowMem[i] <= '0;
    end else if (strobe.rowCe && strobe.wrRow) begin
      rowMem[wrRowAddr] <= wrCount;
    end
  end

  always_comb begin
    rowRdData = (strobe.rowCe && strobe.rowRead) ? rowMem[rdRowAddr] : '0;
    nA = strobe.leftInt ? curFile[addr.leftIdx] : rightFile[addr.rdY];
    nB = strobe.upInt   ? curFile[addr.upIdx]   : rowRdData;
    sumAB = {1'b0, nA} + {1'b0, nB} + {{CNT_W{1'b0}}, 1'b1};
    unique case ({strobe.leftOk, strobe.upOk})
      2'b11:   pick = sumAB[CNT_W:1];
      2'b10:   pick = nA;
      2'b01:   pick = nB;
      default: pick = '0;
    endcase

    if (strobe.chromaDc) begin
      ncNext    = '1;
      tableNext = TAB_CHROMA_DC;
    end else begin
      ncNext = $signed({1'b0, pick});
      if (pick < CNT_W'(2))      tableNext = 3'd0;
      else if (pick < CNT_W'(4)) tableNext = 3'd1;
      else if (pick < CNT_W'(8)) tableNext = 3'd2;
      else                       tableNext = 3'd3;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ncValid  <= 1'b0;
      ncOut    <= '0;
      tableSel <= '0;
    end else begin
      ncValid <= strobe.reqLive;
      if (strobe.reqLive) begin
        ncOut    <= ncNext;
        tableSel <= tableNext;
      end
    end
  end

endmodule

// File: rtl/ctxSel.sv
module ctxSel
  import ctxSelPkg::*;
#(
  parameter int MB_PER_ROW = 22,
  parameter int CNT_W      = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic                          isChromaDc,
  input  logic [3:0]                    blkIdx,
  input  logic [$clog2(MB_PER_ROW)-1:0] mbCol,
  input  logic                          leftAvail,
  input  logic                          upAvail,
  input  logic                          wrEn,
  input  logic [3:0]                    wrBlk,
  input  logic [CNT_W-1:0]              wrCount,
  output logic                          ncValid,
  output logic signed [CNT_W:0]         ncOut,
  output logic [2:0]                    tableSel,
  output logic                          rowMemActive
);

  ctxStrobe_t strobe;
  ctxAddr_t   addr;

  ctxSelCtrl ctrl_i (
    .reqValid   (reqValid),
    .isChromaDc (isChromaDc),
    .blkIdx     (blkIdx),
    .leftAvail  (leftAvail),
    .upAvail    (upAvail),
    .wrEn       (wrEn),
    .wrBlk      (wrBlk),
    .strobe     (strobe),
    .addr       (addr)
  );

  ctxSelDp #(.MB_PER_ROW(MB_PER_ROW), .CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addr     (addr),
    .mbCol    (mbCol),
    .wrBlk    (wrBlk),
    .wrCount  (wrCount),
    .ncValid  (ncValid),
    .ncOut    (ncOut),
    .tableSel (tableSel)
  );

  assign rowMemActive = strobe.rowCe;

endmodule

// File: rtl/ctxSelChk.sv
module ctxSelChk #(
  parameter int MB_PER_ROW = 22,
  parameter int CNT_W      = 5
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          reqValid,
  input logic                          isChromaDc,
  input logic [3:0]                    blkIdx,
  input logic                          leftAvail,
  input logic                          upAvail,
  input logic                          wrEn,
  input logic                          ncValid,
  input logic signed [CNT_W:0]         ncOut,
  input logic [2:0]                    tableSel,
  input logic                          rowMemActive
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ncValid);

  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !ncValid);

  a_r4_chroma_result: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isChromaDc) |=> (int'(ncOut) == -1 && tableSel == 3'd4));

  a_r4_chroma_no_row: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isChromaDc && !wrEn) |-> !rowMemActive);

  a_r3_none_available: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isChromaDc && blkIdx == 4'd0 && !leftAvail && !upAvail) |=> (int'(ncOut) == 0));

  a_r5_table_band: assert property (@(posedge clk) disable iff (!rstN)
    (ncValid && tableSel != 3'd4) |->
      (tableSel == ((int'(ncOut) < 2) ? 3'd0 : (int'(ncOut) < 4) ? 3'd1 :
                    (int'(ncOut) < 8) ? 3'd2 : 3'd3)));

  a_r9_row_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !wrEn) |-> !rowMemActive);

  a_r10_count_range: assert property (@(posedge clk) disable iff (!rstN)
    ncValid |-> (int'(ncOut) >= -1 && int'(ncOut) <= 16));

endmodule

bind ctxSel ctxSelChk #(.MB_PER_ROW(MB_PER_ROW), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .isChromaDc   (isChromaDc),
  .blkIdx       (blkIdx),
  .leftAvail    (leftAvail),
  .upAvail      (upAvail),
  .wrEn         (wrEn),
  .ncValid      (ncValid),
  .ncOut        (ncOut),
  .tableSel     (tableSel),
  .rowMemActive (rowMemActive)
);

// File: tb/ctxSel_tb_top.sv
module ctxSel_tb_top;

  localparam int COLS  = 4;
  localparam int ROWS  = 3;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, isChromaDc = 1'b0, leftAvail = 1'b0, upAvail = 1'b0, wrEn = 1'b0;
  logic [3:0] blkIdx = '0, wrBlk = '0;
  logic [$clog2(COLS)-1:0] mbCol = '0;
  logic [CNT_W-1:0] wrCount = '0;
  logic ncValid, rowMemActive;
  logic signed [CNT_W:0] ncOut;
  logic [2:0] tableSel;

  int vecCnt = 0;
  int errCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ctxSel #(.MB_PER_ROW(COLS), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isChromaDc(isChromaDc),
    .blkIdx(blkIdx), .mbCol(mbCol), .leftAvail(leftAvail), .upAvail(upAvail),
    .wrEn(wrEn), .wrBlk(wrBlk), .wrCount(wrCount), .ncValid(ncValid),
    .ncOut(ncOut), .tableSel(tableSel), .rowMemActive(rowMemActive)
  );

  function automatic int bx(int b); return ((b >> 2) & 1) * 2 + (b & 1); endfunction
  function automatic int by(int b); return ((b >> 3) & 1) * 2 + ((b >> 1) & 1); endfunction
  function automatic int bAt(int x, int y);
    return ((y >> 1) & 1) * 8 + ((x >> 1) & 1) * 4 + (y & 1) * 2 + (x & 1);
  endfunction
  function automatic int expTab(int nc, bit cdc);
    if (cdc) return 4;
    if (nc < 2) return 0;
    if (nc < 4) return 1;
    if (nc < 8) return 2;
    return 3;
  endfunction
  function automatic int cntOf(int p, int r, int c, int b);
    return (r * 37 + c * 11 + b * 5 + p * 3) % 17;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic putCount(int col, int blk, int v);
    @(negedge clk);
    mbCol = col[$clog2(COLS)-1:0]; wrEn = 1'b1; wrBlk = blk[3:0]; wrCount = v[CNT_W-1:0];
    #1 chk(rowMemActive == (by(blk) == 3), "R9 write enable", int'(rowMemActive), int'(by(blk) == 3));
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic askNc(int col, int blk, bit la, bit ua, bit cdc, int expNc, string req);
    bit expCe;
    expCe = !cdc && by(blk) == 0 && ua;
    @(negedge clk);
    mbCol = col[$clog2(COLS)-1:0]; blkIdx = blk[3:0]; leftAvail = la; upAvail = ua;
    isChromaDc = cdc; reqValid = 1'b1;
    #1 chk(rowMemActive == expCe, "R9 read enable", int'(rowMemActive), int'(expCe));
    @(negedge clk);
    reqValid = 1'b0;
    chk(ncValid == 1'b1, "R1 valid", int'(ncValid), 1);
    chk(int'(ncOut) == expNc, req, int'(ncOut), expNc);
    chk(int'(tableSel) == expTab(expNc, cdc), "R5 table", int'(tableSel), expTab(expNc, cdc));
    @(negedge clk);
    chk(ncValid == 1'b0, "R1 valid drop", int'(ncValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ncValid == 1'b0, "R10 reset valid", int'(ncValid), 0);
    chk(int'(ncOut) == 0, "R10 reset nc", int'(ncOut), 0);
    chk(tableSel == 3'd0, "R10 reset table", int'(tableSel), 0);
    rstN = 1'b1;

    // R10: every store reads zero after reset
    askNc(0, 3, 1'b0, 1'b0, 1'b0, 0, "R10 current file clear");
    askNc(2, 0, 1'b1, 1'b1, 1'b0, 0, "R10 edge stores clear");

    // R2 / R5: exhaustive average over both internal neighbours (block 3: left 2, up 1)
    for (int a = 0; a <= 16; a++) begin
      for (int b = 0; b <= 16; b++) begin
        putCount(0, 2, a);
        putCount(0, 1, b);
        askNc(0, 3, 1'b0, 1'b0, 1'b0, (a + b + 1) >> 1, "R2 average (R6 flags ignored)");
      end
    end

    // R11: write colliding with a read sees the old value (cur[2]=16, cur[1]=16)
    @(negedge clk);
    mbCol = '0; wrEn = 1'b1; wrBlk = 4'd2; wrCount = '0;
    blkIdx = 4'd3; isChromaDc = 1'b0; leftAvail = 1'b0; upAvail = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; reqValid = 1'b0;
    chk(int'(ncOut) == 16, "R11 read before write", int'(ncOut), 16);
    askNc(0, 3, 1'b0, 1'b0, 1'b0, 8, "R11 write landed");

    // R3: single neighbour and none
    for (int a = 0; a <= 16; a++) begin
      putCount(0, 0, a);
      askNc(0, 1, 1'b1, 1'b0, 1'b0, a, "R3 left only");
      askNc(0, 2, 1'b0, 1'b1, 1'b0, a, "R3 upper only");
      askNc(0, 0, 1'b0, 1'b0, 1'b0, 0, "R3 none");
    end

    // R6/R7/R8: whole frames under two availability schemes, plus R4 chroma DC
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          bit la, ua;
          la = (p == 0) ? (c > 0) : (c > 0 && ((r + c) % 2 == 0));
          ua = (p == 0) ? (r > 0) : (r > 0 && (c % 2 == 1));
          for (int b = 0; b < 16; b++) begin
            int x, y, nA, nB, e;
            bit hasA, hasB;
            string tag;
            x = bx(b); y = by(b);
            hasA = (x > 0) || la;
            hasB = (y > 0) || ua;
            nA = (x > 0) ? cntOf(p, r, c, bAt(x - 1, y)) : (la ? cntOf(p, r, c - 1, bAt(3, y)) : 0);
            nB = (y > 0) ? cntOf(p, r, c, bAt(x, y - 1)) : (ua ? cntOf(p, r - 1, c, bAt(x, 3)) : 0);
            if (hasA && hasB) e = (nA + nB + 1) >> 1;
            else if (hasA) e = nA;
            else if (hasB) e = nB;
            else e = 0;
            if (x == 0 && la) tag = "R7 previous right column";
            else if (y == 0 && ua) tag = "R8 row memory";
            else tag = "R6 internal neighbours";
            askNc(c, b, la, ua, 1'b0, e, tag);
            putCount(c, b, cntOf(p, r, c, b));
          end
          askNc(c, 0, 1'b1, 1'b1, 1'b1, -1, "R4 chroma DC");
        end
      end
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule